// File: doc/BRIEF.md
# Bit-Reversed Density Modulator for Audio Output

This block turns a 16-bit unsigned audio code into a single-bit stream. The stream is meant to drive a simple analog low-pass filter. A 16-bit sweep counter runs freely through all 65536 codes. Its bits are wired in reverse order, and the reversed value is compared with the sample currently held. Over one full sweep, the pin is high for exactly as many clocks as the held code. Because the reversed order interleaves small and large codes, those high clocks are scattered across the sweep rather than gathered into one wide pulse. This pushes most of the unwanted energy far above the audible band.

A separate count-down timer sets the sample rate. It is not tied to the sweep in any way. Each time the timer expires, it raises a one-clock load strobe, and on the next edge the held sample is replaced with the value on the next-sample input. The sample period can therefore be any number of clocks, and a sample may be dropped before the sweep has visited every code. The logic feeding the block watches the strobe to know when to present the following sample.

Top module: `brpwm_audio_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pdm_out` and `load_strobe` are 0 after that edge. The sweep counter returns to 0, the held sample to 0x8000, and the timer to `DEFAULT_RELOAD`.
- R2: The sweep counter advances by one on every edge after reset and wraps from 0xFFFF to 0. Bit k of the reversed code is bit 15-k of the counter.
- R3: After each edge, `pdm_out` is 1 exactly when the reversed code present before that edge is strictly below the held sample. A held 0x0000 therefore gives a constant 0. A held 0xFFFF gives 1 except when the counter is 0xFFFF.
- R4: Over any 65536 consecutive clocks with a constant held sample S, `pdm_out` is high on exactly S of them.
- R5: The held sample takes the `next_sample` value present at the edge that follows a clock in which `load_strobe` is high. The pin shows the new value from the edge after that. The held sample does not change at any other time.
- R6: Out of reset, the held sample is midscale (0x8000). Until the first load, the pin therefore reads 1, 0, 1, 0, … starting with 1 after the first edge.
- R7: The first `load_strobe` rises after the `DEFAULT_RELOAD`-th edge following reset release and lasts exactly one clock.
- R8: At the edge that ends a strobe clock, the timer reloads from `reload_value` (R ≥ 1). The next strobe follows R edges later, so a constant R gives one strobe every R+1 clocks. A change to `reload_value` affects only intervals that start after the change.
- R9: Sample loads follow only the timer, whatever position the sweep counter has reached, so a sample can be replaced partway through a sweep.
- R10: With the held sample at 0x8000, the pin changes level on every clock: 65536 transitions per sweep. Ordinary pulse-width output gives only 2 at this setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| next_sample | input | CODE_W | Unsigned sample taken on the edge after a strobe |
| reload_value | input | TMR_W | Timer reload count; strobe period is this value plus one |
| pdm_out | output | 1 | Registered single-bit density output |
| load_strobe | output | 1 | One-clock pulse marking the end of a sample period |

## Verification
Every result has a fixed latency in edges:
- The pin reflects the counter and held sample one edge after they are present.
- The held sample follows `next_sample` one edge after a strobe clock, so a new code appears on the pin two edges after the strobe.
- The first strobe appears `DEFAULT_RELOAD` edges after reset release, and each later one comes reload+1 edges after the previous one.

The bench keeps a reference model written from these rules and steps it once per rising edge, using the input values present at that edge. It samples the outputs a quarter period after the edge and changes inputs only after sampling. Counting windows of 65536 clocks start only after two complete sample periods have passed with a constant `next_sample`.

// File: rtl/brpwm_pkg.sv
// Package: shared widths and defaults for the bit-reversed density modulator.
// Assumes the code width is also the sweep counter width (full power-of-two sweep).
package brpwm_pkg;
    localparam int unsigned BRP_CODE_W     = 16;
    localparam int unsigned BRP_TMR_W      = 16;
    localparam int unsigned BRP_DEF_RELOAD = 1024;
endpackage

// File: rtl/brpwm_sweep_counter.sv
// Module: free-running sweep counter with a bit-reversed view.
// What it does: counts every clock through all 2^CNT_W codes and exposes the
//   counter with its bit order reversed (pure rewiring, no logic).
// Assumes: synchronous active-low reset; the counter width equals the code width.
module brpwm_sweep_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_rev
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    // Advance the sweep by one code every clock, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CNT_ONE;
        end
    end

    // Reverse the bit order: bit k of the output is bit CNT_W-1-k of the counter.
    for (genvar k = 0; k < CNT_W; k++) begin : g_rev
        assign count_rev[k] = count_q[CNT_W-1-k];
    end

    // R2: the counter steps by exactly one on each edge after reset.
    assert_sweep_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count_q == $past(count_q) + CNT_ONE));
endmodule

// File: rtl/brpwm_rate_timer.sv
// Module: sample-rate count-down timer.
// What it does: counts down once per clock and raises a one-clock load strobe
//   after the count has been 1; on the edge ending the strobe it reloads.
// Assumes: reload_value >= 1 and DEFAULT_RELOAD >= 1; not linked to the sweep.
module brpwm_rate_timer #(
    parameter int unsigned         TMR_W          = 16,
    parameter logic [TMR_W-1:0]    DEFAULT_RELOAD = TMR_W'(1024)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] reload_value,
    output logic             load_strobe
);
    localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

    logic [TMR_W-1:0] tmr_q;

    // Raise the strobe for one clock when the count has reached one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_strobe <= 1'b0;
        end else begin
            load_strobe <= (tmr_q == TMR_ONE);
        end
    end

    // Count down each clock; reload right after the strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= DEFAULT_RELOAD;
        end else if (load_strobe) begin
            tmr_q <= reload_value;
        end else begin
            tmr_q <= tmr_q - TMR_ONE;
        end
    end

    // R7: the strobe never lasts more than one clock.
    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);

    // R8: the interval after a strobe starts from the reload input seen at that edge.
    assert_reload_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> (tmr_q == $past(reload_value)));
endmodule

// File: rtl/brpwm_density_cmp.sv
// Module: held sample register and registered density comparator.
// What it does: keeps the current sample, replaces it on the load strobe, and
//   drives the pin high when the reversed sweep code is strictly below it.
// Assumes: count_rev visits every code once per sweep; RESET_CODE is midscale.
module brpwm_density_cmp #(
    parameter int unsigned       CODE_W     = 16,
    parameter logic [CODE_W-1:0] RESET_CODE = {1'b1, {(CODE_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_strobe,
    input  logic [CODE_W-1:0] next_sample,
    input  logic [CODE_W-1:0] count_rev,
    output logic              pdm_out
);
    logic [CODE_W-1:0] held_q;

    // Take a new sample only on the clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= RESET_CODE;
        end else if (load_strobe) begin
            held_q <= next_sample;
        end
    end

    // Register the density decision every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdm_out <= 1'b0;
        end else begin
            pdm_out <= (count_rev < held_q);
        end
    end

    // R5: a strobe hands the next-sample input to the held register.
    assert_load_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> (held_q == $past(next_sample)));

    // R5: without a strobe the held sample stays put.
    assert_load_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |=> $stable(held_q));

    // R3: a zero sample keeps the pin low.
    assert_zero_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == '0) |=> !pdm_out);

    // R3: a full-scale sample keeps the pin high except at the top code.
    assert_full_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((held_q == '1) && (count_rev != '1)) |=> pdm_out);
endmodule

// File: rtl/brpwm_audio_mod.sv
// Module: bit-reversed density modulator, top level.
// What it does: ties the sweep counter, the sample-rate timer and the
//   comparator together; the timer and sweep run independently.
// Assumes: synchronous active-low reset; reload_value >= 1.
module brpwm_audio_mod
    import brpwm_pkg::*;
#(
    parameter int unsigned      CODE_W         = BRP_CODE_W,
    parameter int unsigned      TMR_W          = BRP_TMR_W,
    parameter logic [TMR_W-1:0] DEFAULT_RELOAD = TMR_W'(BRP_DEF_RELOAD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] next_sample,
    input  logic [TMR_W-1:0]  reload_value,
    output logic              pdm_out,
    output logic              load_strobe
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] sweep_rev;

    brpwm_sweep_counter #(
        .CNT_W (CODE_W)
    ) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_rev (sweep_rev)
    );

    brpwm_rate_timer #(
        .TMR_W          (TMR_W),
        .DEFAULT_RELOAD (DEFAULT_RELOAD)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_value (reload_value),
        .load_strobe  (load_strobe)
    );

    brpwm_density_cmp #(
        .CODE_W     (CODE_W),
        .RESET_CODE (MID_CODE)
    ) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_strobe (load_strobe),
        .next_sample (next_sample),
        .count_rev   (sweep_rev),
        .pdm_out     (pdm_out)
    );
endmodule

// File: tb/test_brpwm_audio_mod.sv
// Bench: directed scenarios against a reference model written from the requirements.
module test_brpwm_audio_mod;
    localparam int CLK_P = 10;
    localparam int DREL  = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] next_sample = 16'hFFFF;
    logic [15:0] reload_value = 16'd7;
    logic        pdm_out;
    logic        load_strobe;

    int checks = 0;
    int errors = 0;
    int n = 0;

    // Reference model state
    logic [15:0] m_cnt = 16'h0000;
    logic [15:0] m_held = 16'h8000;
    logic        m_prev_strobe = 1'b0;
    int          m_next_edge = DREL;
    logic        exp_pin = 1'b0;
    logic        exp_strobe = 1'b0;
    logic        act_pin = 1'b0;
    logic        act_strobe = 1'b0;

    brpwm_audio_mod #(
        .CODE_W         (16),
        .TMR_W          (16),
        .DEFAULT_RELOAD (16'(DREL))
    ) i_brpwm_audio_mod (
        .clk          (clk),
        .rst_n        (rst_n),
        .next_sample  (next_sample),
        .reload_value (reload_value),
        .pdm_out      (pdm_out),
        .load_strobe  (load_strobe)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = v[15-k];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One rising edge: advance the model, then sample outputs a quarter period later.
    task automatic tick();
        @(posedge clk);
        n++;
        exp_pin = (rev16(m_cnt) < m_held);
        if (m_prev_strobe) begin
            m_held = next_sample;
            m_next_edge = n + int'(reload_value);
        end
        exp_strobe = (n == m_next_edge);
        m_prev_strobe = exp_strobe;
        m_cnt = m_cnt + 16'd1;
        #(CLK_P/4);
        act_pin = pdm_out;
        act_strobe = load_strobe;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        chk(pdm_out == 1'b0, "R1", "pin in reset", pdm_out, 0);
        chk(load_strobe == 1'b0, "R1", "strobe in reset", load_strobe, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_midscale_start();
        int bad = 0;
        int bad_s = 0;
        for (int i = 1; i <= 20; i++) begin
            tick();
            if (act_pin != ((n % 2) == 1)) bad++;
            if (act_strobe) bad_s++;
        end
        chk(bad == 0, "R6", "alternating pin from midscale reset", bad, 0);
        chk(bad_s == 0, "R7", "no strobe before default count", bad_s, 0);
    endtask

    task automatic t_first_load();
        tick();
        chk(act_strobe == 1'b1, "R7", "first strobe at default count", act_strobe, 1);
        tick();
        chk(act_strobe == 1'b0, "R7", "strobe one clock only", act_strobe, 0);
        chk(act_pin == 1'b0, "R5", "old sample still on pin", act_pin, 0);
        tick();
        chk(act_pin == 1'b1, "R5", "new full-scale sample on pin", act_pin, 1);
        tick();
        chk(act_pin == 1'b1, "R5", "new sample second clock", act_pin, 1);
    endtask

    task automatic t_strobe_period();
        int bad = 0;
        int seen = 0;
        for (int i = 0; i < 64; i++) begin
            tick();
            if (act_strobe != exp_strobe) bad++;
            if (act_strobe) seen++;
        end
        chk(bad == 0, "R8", "strobe schedule with reload 7", bad, 0);
        chk(seen == 8, "R8", "strobes in 64 clocks", seen, 8);
    endtask

    task automatic t_reload_change();
        int bad = 0;
        int seen = 0;
        reload_value = 16'd3;
        for (int i = 0; i < 48; i++) begin
            tick();
            if (act_strobe != exp_strobe) bad++;
            if (act_strobe) seen++;
        end
        chk(bad == 0, "R8", "strobe schedule after reload change", bad, 0);
        chk(seen >= 10, "R8", "faster strobes with reload 3", seen, 10);
        reload_value = 16'd7;
        repeat (20) tick();
    endtask

    task automatic t_count_window(input logic [15:0] s);
        int ones = 0;
        next_sample = s;
        repeat (20) tick();
        for (int i = 0; i < 65536; i++) begin
            tick();
            if (act_pin) ones++;
        end
        chk(ones == int'(s), "R4", "ones over one sweep", ones, int'(s));
    endtask

    task automatic t_midscale_window();
        int ones = 0;
        int edges = 0;
        logic prev;
        next_sample = 16'h8000;
        repeat (20) tick();
        prev = act_pin;
        for (int i = 0; i < 65536; i++) begin
            tick();
            if (act_pin) ones++;
            if (act_pin != prev) edges++;
            prev = act_pin;
        end
        chk(ones == 32768, "R4", "midscale ones over one sweep", ones, 32768);
        chk(edges == 65536, "R10", "midscale transitions per sweep", edges, 65536);
    endtask

    task automatic t_extremes();
        int lit = 0;
        int bad = 0;
        next_sample = 16'h0000;
        repeat (20) tick();
        for (int i = 0; i < 2048; i++) begin
            tick();
            if (act_pin) lit++;
        end
        chk(lit == 0, "R3", "zero sample keeps pin low", lit, 0);
        next_sample = 16'hFFFF;
        repeat (20) tick();
        for (int i = 0; i < 2048; i++) begin
            tick();
            if (act_pin != exp_pin) bad++;
        end
        chk(bad == 0, "R3", "full-scale sample pin pattern", bad, 0);
    endtask

    task automatic t_tracking();
        logic [15:0] lfsr = 16'hACE1;
        int bad_p = 0;
        int bad_s = 0;
        reload_value = 16'd5;
        for (int i = 0; i < 4000; i++) begin
            tick();
            if (act_pin != exp_pin) bad_p++;
            if (act_strobe != exp_strobe) bad_s++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            next_sample = lfsr;
        end
        chk(bad_p == 0, "R9", "pin tracks mid-sweep sample changes", bad_p, 0);
        chk(bad_s == 0, "R8", "strobe with reload 5 while sweeping", bad_s, 0);
        chk(bad_p == 0, "R2", "reversed sweep order on pin", bad_p, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_midscale_start();
        t_first_load();
        t_strobe_period();
        t_reload_change();
        t_count_window(16'h1234);
        t_midscale_window();
        t_extremes();
        t_tracking();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule